// File: doc/BRIEF.md
# Test Coprocessor with Stall Timer and Delayed Interrupts

This block is a coprocessor used for processor validation. It answers requests on two coprocessor numbers, which both reach one shared file of sixteen 32-bit registers. Either number can move a register to or from the core. Only the main number (4) accepts memory load and store transfers. A store or load can be a single word or a long burst. Data operations are chosen by a 4-bit opcode. They stall the core for a number of cycles held in a register, assert an active-low FIQ or IRQ line after a delay held in a register, release those lines, or copy a free-running cycle counter into a register.

The core presents one request per cycle. A request carries a kind, a coprocessor number, an instruction word, write data and a phase flag. The flag marks the first cycle of a data operation, or the non-data setup phase of a load or store. The response code and any read data are combinational in the same cycle. Register, counter and interrupt-line updates take effect at the next clock edge.

Top module: `valcp_unit`

## Requirements
- R1: After reset, every register reads 0, fiqN and irqN are high, and the cycle counter is 0. The counter increments at every clock edge out of reset and wraps at 32 bits.
- R2: A read (kind 1'b0 encoded 3'd0) or write (kind 3'd1) on coprocessor 4 or 5 returns DONE. It uses instruction bits 19:16 as the register index, and both numbers reach the same register file. Response codes are DONE=0, BUSY=1, INC=2, CANT=3.
- R3: A load (kind 3'd2) or store (kind 3'd3) on coprocessor 4 indexes the register with bits 15:12. A load writes the data word and a store returns the register on rspRdata. On coprocessor 5 both kinds answer CANT and change no register.
- R4: A load or store with reqFirst=1 is the non-data phase. It answers DONE and clears the burst word counter. With bit 22 clear, one data phase moves one word and answers DONE.
- R5: With bit 22 set, the data phases of a load or store answer INC for the first four words and DONE on the fifth word.
- R6: Opcode 0 (bits 23:20) is a busy wait on both numbers. The count is read from the register selected by bits 3:0. On the first cycle, at counter value c, the finish time becomes c plus the count, and the response is DONE if the count is 0 and BUSY otherwise. A later poll answers DONE once the counter is at or past the finish time.
- R7: Opcode 1 on coprocessor 5 answers DONE. fiqN goes low N clock edges after the request edge, where N is the count register. If N is 0, fiqN goes low at the request edge.
- R8: Opcode 2 on coprocessor 5 does the same for irqN.
- R9: Opcode 3 drives fiqN high and opcode 4 drives irqN high at the request edge. Only coprocessor 5 accepts these opcodes.
- R10: Opcode 5 on coprocessor 5 writes the counter value of the request cycle into the register selected by bits 3:0.
- R11: The following answer CANT and leave registers and lines unchanged: any nonzero opcode on coprocessor 4, opcodes above 5 on coprocessor 5, any other coprocessor number, and any unknown kind.
- R12: A new FIQ or IRQ schedule replaces a countdown of the same type that is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqFirst | input | 1 | First cycle of a data operation, or non-data phase of a load/store |
| reqKind | input | 3 | 0 read, 1 write, 2 load, 3 store, 4 data operation |
| reqCp | input | 4 | Coprocessor number |
| reqInstr | input | 32 | Instruction word (fields at 23:20, 22, 19:16, 15:12, 3:0) |
| reqWdata | input | 32 | Data for write or load |
| rspCode | output | 2 | DONE / BUSY / INC / CANT |
| rspRdata | output | 32 | Data for read or store |
| fiqN | output | 1 | Active-low fast interrupt |
| irqN | output | 1 | Active-low interrupt |

## Verification
The busy wait is tried three ways: with a zero count, with polls every cycle, and with polling that starts after the finish time. Together these separate an immediate answer, exact finish-edge timing, and a counter-based (not poll-counted) completion. Delayed interrupts are scheduled with zero and nonzero counts, then rescheduled while a long countdown is running. A release followed by a long idle window shows that the replaced countdown never fires. Long bursts run to completion and are also cut short by a new setup phase, which checks the word counter clear. The refused cases are each followed by a read-back or by the line outputs, so that any unwanted change becomes visible.

// File: rtl/valcp_pkg.sv
package valcp_pkg;
  localparam int FIELD_W = 4;

  typedef enum logic [1:0] {
    RSP_DONE = 2'd0,
    RSP_BUSY = 2'd1,
    RSP_INC  = 2'd2,
    RSP_CANT = 2'd3
  } rsp_e;

  typedef enum logic [2:0] {
    KIND_READ  = 3'd0,
    KIND_WRITE = 3'd1,
    KIND_LOAD  = 3'd2,
    KIND_STORE = 3'd3,
    KIND_OP    = 3'd4
  } kind_e;

  typedef enum logic [FIELD_W-1:0] {
    OP_WAIT    = 4'd0,
    OP_FIQ_SET = 4'd1,
    OP_IRQ_SET = 4'd2,
    OP_FIQ_CLR = 4'd3,
    OP_IRQ_CLR = 4'd4,
    OP_STAMP   = 4'd5
  } opc_e;

  typedef struct packed {
    logic               wrEn;
    logic               wrStamp;
    logic [FIELD_W-1:0] wrIdx;
    logic               finishLoad;
    logic               fiqArm;
    logic               irqArm;
    logic               fiqRel;
    logic               irqRel;
  } strobe_t;
endpackage

// File: rtl/valcp_alarm.sv
module valcp_alarm #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             arm,
  input  logic             clear,
  input  logic [CNT_W-1:0] armCount,
  output logic             lineN
);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      left  <= '0;
      lineN <= 1'b1;
    end else begin
      if (arm) begin
        left <= armCount;
        if (armCount == '0) lineN <= 1'b0;
      end else if (left != '0) begin
        left <= left - 1'b1;
        if (left == CNT_W'(1)) lineN <= 1'b0;
      end
      if (clear) lineN <= 1'b1;
    end
  end

  // R7 and R8: the line only falls on a zero-count arm or on countdown expiry
  assert_fall_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineN) |-> ($past(arm && armCount == '0) || $past(!arm && left == CNT_W'(1))));

  // R9: the line only rises on a release request
  assert_rise_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineN) |-> $past(clear));
endmodule

// File: rtl/valcp_dpath.sv
module valcp_dpath
  import valcp_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NUM_REGS = 2 ** FIELD_W,
  localparam int NUM_LINES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [FIELD_W-1:0] rdIdx,
  input  logic [FIELD_W-1:0] opIdx,
  output logic [DATA_W-1:0]  rdData,
  output logic               opZero,
  output logic               finishReached,
  output logic               fiqN,
  output logic               irqN
);
  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] cycleCnt;
  logic [DATA_W-1:0] finishAt;
  logic [DATA_W-1:0] wrValue;
  logic [DATA_W-1:0] opVal;
  logic [DATA_W-1:0] gap;
  logic [NUM_LINES-1:0] armVec, clrVec, lineVec;

  assign wrValue = strb.wrStamp ? cycleCnt : wrData;
  assign rdData  = regFile[rdIdx];
  assign opVal   = regFile[opIdx];
  assign opZero  = (opVal == '0);
  assign gap     = cycleCnt - finishAt;
  assign finishReached = !gap[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (strb.wrEn) begin
      regFile[strb.wrIdx] <= wrValue;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleCnt <= '0;
      finishAt <= '0;
    end else begin
      cycleCnt <= cycleCnt + 1'b1;
      if (strb.finishLoad) finishAt <= cycleCnt + opVal;
    end
  end

  assign armVec = {strb.irqArm, strb.fiqArm};
  assign clrVec = {strb.irqRel, strb.fiqRel};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_alarm
    valcp_alarm #(.CNT_W(DATA_W)) u_alarm (
      .clk      (clk),
      .rstN     (rstN),
      .arm      (armVec[g]),
      .clear    (clrVec[g]),
      .armCount (opVal),
      .lineN    (lineVec[g])
    );
  end

  assign fiqN = lineVec[0];
  assign irqN = lineVec[1];

  // R1: free-running counter steps by one every edge out of reset
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> cycleCnt == $past(cycleCnt) + 1'b1);

  // R10: a stamp write stores the counter value of the request cycle
  assert_stamp_value_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrStamp) |=> regFile[$past(strb.wrIdx)] == $past(cycleCnt));
endmodule

// File: rtl/valcp_ctrl.sv
module valcp_ctrl
  import valcp_pkg::*;
#(
  parameter logic [3:0] CP_MAIN = 4'd4,
  parameter logic [3:0] CP_AUX  = 4'd5,
  parameter int LONG_BEATS = 5,
  localparam int BEAT_W = $clog2(LONG_BEATS + 1),
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LONG_BEATS - 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqFirst,
  input  logic [2:0]         reqKind,
  input  logic [3:0]         reqCp,
  input  logic [FIELD_W-1:0] opField,
  input  logic [FIELD_W-1:0] crn,
  input  logic [FIELD_W-1:0] crd,
  input  logic [FIELD_W-1:0] crm,
  input  logic               longXfer,
  input  logic               opZero,
  input  logic               finishReached,
  output strobe_t            strb,
  output rsp_e               rspCode,
  output logic [FIELD_W-1:0] rdIdx,
  output logic [FIELD_W-1:0] opIdx
);
  logic [BEAT_W-1:0] beatCnt, beatNext;
  logic isMain, isAux, owned;

  assign isMain = (reqCp == CP_MAIN);
  assign isAux  = (reqCp == CP_AUX);
  assign owned  = isMain || isAux;
  assign rdIdx  = (reqKind == KIND_STORE) ? crd : crn;
  assign opIdx  = crm;

  always_comb begin
    strb       = '0;
    strb.wrIdx = crn;
    rspCode    = RSP_CANT;
    beatNext   = beatCnt;
    if (reqValid) begin
      case (reqKind)
        KIND_READ: if (owned) rspCode = RSP_DONE;
        KIND_WRITE: if (owned) begin
          rspCode   = RSP_DONE;
          strb.wrEn = 1'b1;
        end
        KIND_LOAD, KIND_STORE: if (isMain) begin
          if (reqFirst) begin
            rspCode  = RSP_DONE;
            beatNext = '0;
          end else begin
            if (reqKind == KIND_LOAD) begin
              strb.wrEn  = 1'b1;
              strb.wrIdx = crd;
            end
            if (!longXfer) begin
              rspCode = RSP_DONE;
            end else if (beatCnt == LAST_BEAT) begin
              rspCode  = RSP_DONE;
              beatNext = '0;
            end else begin
              rspCode  = RSP_INC;
              beatNext = beatCnt + 1'b1;
            end
          end
        end
        KIND_OP: if (owned) begin
          case (opField)
            OP_WAIT: begin
              if (reqFirst) begin
                strb.finishLoad = 1'b1;
                rspCode = opZero ? RSP_DONE : RSP_BUSY;
              end else begin
                rspCode = finishReached ? RSP_DONE : RSP_BUSY;
              end
            end
            OP_FIQ_SET: if (isAux) begin
              strb.fiqArm = 1'b1;
              rspCode     = RSP_DONE;
            end
            OP_IRQ_SET: if (isAux) begin
              strb.irqArm = 1'b1;
              rspCode     = RSP_DONE;
            end
            OP_FIQ_CLR: if (isAux) begin
              strb.fiqRel = 1'b1;
              rspCode     = RSP_DONE;
            end
            OP_IRQ_CLR: if (isAux) begin
              strb.irqRel = 1'b1;
              rspCode     = RSP_DONE;
            end
            OP_STAMP: if (isAux) begin
              strb.wrEn    = 1'b1;
              strb.wrStamp = 1'b1;
              strb.wrIdx   = crm;
              rspCode      = RSP_DONE;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) beatCnt <= '0;
    else       beatCnt <= beatNext;
  end

  assert_beat_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    beatCnt <= LAST_BEAT);

  assert_inc_needs_long_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspCode == RSP_INC) |-> (longXfer && isMain && !reqFirst));

  assert_aux_refuses_mem_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isAux && (reqKind == KIND_LOAD || reqKind == KIND_STORE))
      |-> (rspCode == RSP_CANT && !strb.wrEn));

  assert_main_opcode_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isMain && reqKind == KIND_OP && opField != OP_WAIT)
      |-> (rspCode == RSP_CANT && !strb.wrEn && !strb.fiqArm && !strb.irqArm));
endmodule

// File: rtl/valcp_unit.sv
module valcp_unit
  import valcp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [3:0] CP_MAIN = 4'd4,
  parameter logic [3:0] CP_AUX  = 4'd5,
  parameter int LONG_BEATS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqFirst,
  input  logic [2:0]        reqKind,
  input  logic [3:0]        reqCp,
  input  logic [31:0]       reqInstr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [1:0]        rspCode,
  output logic [DATA_W-1:0] rspRdata,
  output logic              fiqN,
  output logic              irqN
);
  strobe_t            strb;
  rsp_e               rspEnum;
  logic [FIELD_W-1:0] rdIdx, opIdx;
  logic               opZero, finishReached;
  logic               unusedInstr;

  assign unusedInstr = ^{reqInstr[31:24], reqInstr[11:4]};

  valcp_ctrl #(
    .CP_MAIN    (CP_MAIN),
    .CP_AUX     (CP_AUX),
    .LONG_BEATS (LONG_BEATS)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqFirst      (reqFirst),
    .reqKind       (reqKind),
    .reqCp         (reqCp),
    .opField       (reqInstr[23:20]),
    .crn           (reqInstr[19:16]),
    .crd           (reqInstr[15:12]),
    .crm           (reqInstr[3:0]),
    .longXfer      (reqInstr[22]),
    .opZero        (opZero),
    .finishReached (finishReached),
    .strb          (strb),
    .rspCode       (rspEnum),
    .rdIdx         (rdIdx),
    .opIdx         (opIdx)
  );

  valcp_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .wrData        (reqWdata),
    .rdIdx         (rdIdx),
    .opIdx         (opIdx),
    .rdData        (rspRdata),
    .opZero        (opZero),
    .finishReached (finishReached),
    .fiqN          (fiqN),
    .irqN          (irqN)
  );

  assign rspCode = rspEnum;
endmodule

// File: tb/valcp_unit_tb.sv
`timescale 1ns/1ps
module valcp_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqFirst = 1'b0;
  logic [2:0]  reqKind = '0;
  logic [3:0]  reqCp = '0;
  logic [31:0] reqInstr = '0;
  logic [31:0] reqWdata = '0;
  logic [1:0]  rspCode;
  logic [31:0] rspRdata;
  logic        fiqN, irqN;

  always #2.5 clk = ~clk;

  valcp_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqFirst(reqFirst),
    .reqKind(reqKind), .reqCp(reqCp), .reqInstr(reqInstr), .reqWdata(reqWdata),
    .rspCode(rspCode), .rspRdata(rspRdata), .fiqN(fiqN), .irqN(irqN)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  int unsigned mReg [16];
  longint cyc = 0, fiqDue = 0, irqDue = 0, finishM = 0;
  bit fiqPend = 0, irqPend = 0, fiqLow = 0, irqLow = 0;
  int words = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(int op, int n, int d, int m, bit lng);
    logic [31:0] w;
    w = {8'h00, op[3:0], n[3:0], d[3:0], 8'h00, m[3:0]};
    if (lng) w[22] = 1'b1;
    return w;
  endfunction

  function automatic void evalReq(input bit commit, output logic [1:0] expCode,
                                  output logic [31:0] expData, output bit dataValid);
    int n = int'(reqInstr[19:16]);
    int d = int'(reqInstr[15:12]);
    int m = int'(reqInstr[3:0]);
    int op = int'(reqInstr[23:20]);
    bit a = (reqCp == 4'd4);
    bit b = (reqCp == 4'd5);
    expCode = 2'd3; expData = '0; dataValid = 0;
    if (!reqValid) return;
    case (reqKind)
      3'd0: if (a || b) begin expCode = 2'd0; expData = mReg[n]; dataValid = 1; end
      3'd1: if (a || b) begin expCode = 2'd0; if (commit) mReg[n] = reqWdata; end
      3'd2, 3'd3: if (a) begin
        if (reqFirst) begin
          expCode = 2'd0;
          if (commit) words = 0;
        end else begin
          if (reqKind == 3'd2 && commit) mReg[d] = reqWdata;
          if (reqKind == 3'd3) begin expData = mReg[d]; dataValid = 1; end
          if (!reqInstr[22]) expCode = 2'd0;
          else begin
            expCode = (words == 4) ? 2'd0 : 2'd2;
            if (commit) words = (words == 4) ? 0 : words + 1;
          end
        end
      end
      3'd4: if (a || b) begin
        if (op == 0) begin
          if (reqFirst) begin
            expCode = (mReg[m] == 0) ? 2'd0 : 2'd1;
            if (commit) finishM = cyc + longint'(mReg[m]);
          end else begin
            expCode = (cyc >= finishM) ? 2'd0 : 2'd1;
          end
        end else if (b && op <= 5) begin
          expCode = 2'd0;
          if (commit) begin
            case (op)
              1: if (mReg[m] == 0) begin fiqLow = 1; fiqPend = 0; end
                 else begin fiqPend = 1; fiqDue = cyc + 1 + longint'(mReg[m]); end
              2: if (mReg[m] == 0) begin irqLow = 1; irqPend = 0; end
                 else begin irqPend = 1; irqDue = cyc + 1 + longint'(mReg[m]); end
              3: fiqLow = 0;
              4: irqLow = 0;
              default: mReg[m] = cyc[31:0];
            endcase
          end
        end
      end
      default: ;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [1:0] c;
    logic [31:0] dd;
    bit v;
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mReg[i] = 0;
      cyc = 0; fiqPend = 0; irqPend = 0; fiqLow = 0; irqLow = 0; words = 0; finishM = 0;
    end else begin
      evalReq(1, c, dd, v);
      cyc++;
      if (fiqPend && cyc >= fiqDue) begin fiqLow = 1; fiqPend = 0; end
      if (irqPend && cyc >= irqDue) begin irqLow = 1; irqPend = 0; end
    end
  end

  // line comparison every clock: R7 R8 R9 R12
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(fiqN == !fiqLow, "R7 R9 R12 fiqN line", {31'd0, fiqN}, {31'd0, !fiqLow});
      check(irqN == !irqLow, "R8 R9 irqN line", {31'd0, irqN}, {31'd0, !irqLow});
    end
  end

  task automatic issue(input logic [2:0] k, input logic [3:0] cp, input logic [31:0] ins,
                       input logic [31:0] wd, input bit first, input string tag,
                       output logic [1:0] got);
    logic [1:0] ec;
    logic [31:0] ed;
    bit dv;
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqCp = cp; reqInstr = ins; reqWdata = wd; reqFirst = first;
    #1;
    evalReq(0, ec, ed, dv);
    check(rspCode == ec, {tag, " response"}, {30'd0, rspCode}, {30'd0, ec});
    if (dv && ec != 2'd3) check(rspRdata == ed, {tag, " data"}, rspRdata, ed);
    got = rspCode;
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  initial begin
    #(200000 * 5.0);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [1:0] r;
    int polls;
    repeat (3) @(negedge clk);
    check(fiqN && irqN, "R1 lines high in reset", {30'd0, fiqN, irqN}, 32'h3);
    rstN = 1'b1;

    // R1: all registers clear
    for (int i = 0; i < 16; i++) issue(3'd0, 4'd4, mk(0, i, 0, 0, 0), 0, 0, "R1 reset read", r);

    // R2: shared file across both numbers
    issue(3'd1, 4'd4, mk(0, 3, 0, 0, 0), 32'hA5A5_0003, 0, "R2 write cp4", r);
    issue(3'd0, 4'd5, mk(0, 3, 0, 0, 0), 0, 0, "R2 read cp5", r);
    issue(3'd1, 4'd5, mk(0, 15, 0, 0, 0), 32'h1234_5678, 0, "R2 write cp5", r);
    issue(3'd0, 4'd4, mk(0, 15, 0, 0, 0), 0, 0, "R2 read cp4", r);

    // R3 R4: single-word load and store on cp4
    issue(3'd2, 4'd4, mk(0, 0, 7, 0, 0), 0, 1, "R4 load setup", r);
    issue(3'd2, 4'd4, mk(0, 0, 7, 0, 0), 32'hCAFE_0007, 0, "R3 R4 load word", r);
    issue(3'd0, 4'd4, mk(0, 7, 0, 0, 0), 0, 0, "R3 load readback", r);
    issue(3'd3, 4'd4, mk(0, 0, 7, 0, 0), 0, 1, "R4 store setup", r);
    issue(3'd3, 4'd4, mk(0, 0, 7, 0, 0), 0, 0, "R3 store word", r);
    // R3: cp5 refuses memory transfers
    issue(3'd2, 4'd5, mk(0, 0, 7, 0, 0), 0, 1, "R3 cp5 load setup", r);
    issue(3'd2, 4'd5, mk(0, 0, 7, 0, 0), 32'hDEAD_BEEF, 0, "R3 cp5 load", r);
    issue(3'd3, 4'd5, mk(0, 0, 7, 0, 0), 0, 0, "R3 cp5 store", r);
    issue(3'd0, 4'd4, mk(0, 7, 0, 0, 0), 0, 0, "R3 unchanged after cp5", r);

    // R5: long load and store bursts
    issue(3'd2, 4'd4, mk(0, 0, 8, 0, 1), 0, 1, "R5 long load setup", r);
    for (int i = 0; i < 5; i++) issue(3'd2, 4'd4, mk(0, 0, 8, 0, 1), 32'h100 + i, 0, "R5 long load", r);
    check(r == 2'd0, "R5 fifth word done", {30'd0, r}, 32'd0);
    issue(3'd3, 4'd4, mk(0, 0, 8, 0, 1), 0, 1, "R5 long store setup", r);
    for (int i = 0; i < 5; i++) issue(3'd3, 4'd4, mk(0, 0, 8, 0, 1), 0, 0, "R5 long store", r);
    // R4: setup phase restarts a partial burst
    issue(3'd2, 4'd4, mk(0, 0, 9, 0, 1), 0, 1, "R4 burst setup", r);
    for (int i = 0; i < 2; i++) issue(3'd2, 4'd4, mk(0, 0, 9, 0, 1), 32'h55, 0, "R4 partial", r);
    issue(3'd2, 4'd4, mk(0, 0, 9, 0, 1), 0, 1, "R4 restart setup", r);
    for (int i = 0; i < 5; i++) issue(3'd2, 4'd4, mk(0, 0, 9, 0, 1), 32'h0, 0, "R4 R5 restarted", r);

    // R6: busy wait, every-cycle polling
    issue(3'd1, 4'd4, mk(0, 2, 0, 0, 0), 32'd5, 0, "R6 set count", r);
    issue(3'd4, 4'd4, mk(0, 0, 0, 2, 0), 0, 1, "R6 wait first", r);
    polls = 0;
    while (r == 2'd1 && polls < 40) begin
      issue(3'd4, 4'd4, mk(0, 0, 0, 2, 0), 0, 0, "R6 wait poll", r);
      polls++;
    end
    check(polls == 5, "R6 poll count", polls, 32'd5);
    // R6: zero count finishes at once
    issue(3'd4, 4'd5, mk(0, 0, 0, 9, 0), 0, 1, "R6 zero wait", r);
    // R6: late poll completes from the counter
    issue(3'd4, 4'd5, mk(0, 0, 0, 2, 0), 0, 1, "R6 late first", r);
    idle(10);
    issue(3'd4, 4'd5, mk(0, 0, 0, 2, 0), 0, 0, "R6 late poll", r);

    // R7: delayed FIQ, then R9 release
    issue(3'd1, 4'd5, mk(0, 4, 0, 0, 0), 32'd10, 0, "R7 set delay", r);
    issue(3'd4, 4'd5, mk(1, 0, 0, 4, 0), 0, 0, "R7 arm fiq", r);
    idle(14);
    check(fiqN == 1'b0, "R7 fiq low after delay", {31'd0, fiqN}, 32'd0);
    issue(3'd4, 4'd5, mk(3, 0, 0, 0, 0), 0, 0, "R9 release fiq", r);
    idle(1);
    check(fiqN == 1'b1, "R9 fiq released", {31'd0, fiqN}, 32'd1);

    // R8: immediate IRQ, release
    issue(3'd4, 4'd5, mk(2, 0, 0, 9, 0), 0, 0, "R8 arm irq zero", r);
    idle(1);
    check(irqN == 1'b0, "R8 irq immediate", {31'd0, irqN}, 32'd0);
    issue(3'd4, 4'd5, mk(4, 0, 0, 0, 0), 0, 0, "R9 release irq", r);
    // R8: delayed IRQ
    issue(3'd4, 4'd5, mk(2, 0, 0, 2, 0), 0, 0, "R8 arm irq delayed", r);
    idle(8);
    issue(3'd4, 4'd5, mk(4, 0, 0, 0, 0), 0, 0, "R9 release irq again", r);

    // R12: reschedule replaces a running countdown
    issue(3'd1, 4'd5, mk(0, 4, 0, 0, 0), 32'd20, 0, "R12 long delay", r);
    issue(3'd1, 4'd5, mk(0, 5, 0, 0, 0), 32'd3, 0, "R12 short delay", r);
    issue(3'd4, 4'd5, mk(1, 0, 0, 4, 0), 0, 0, "R12 arm long", r);
    idle(5);
    issue(3'd4, 4'd5, mk(1, 0, 0, 5, 0), 0, 0, "R12 arm short", r);
    idle(4);
    check(fiqN == 1'b0, "R12 short schedule fired", {31'd0, fiqN}, 32'd0);
    issue(3'd4, 4'd5, mk(3, 0, 0, 0, 0), 0, 0, "R12 release", r);
    idle(25);
    check(fiqN == 1'b1, "R12 old countdown gone", {31'd0, fiqN}, 32'd1);

    // R10: counter capture
    issue(3'd4, 4'd5, mk(5, 0, 0, 11, 0), 0, 0, "R10 stamp", r);
    issue(3'd0, 4'd4, mk(0, 11, 0, 0, 0), 0, 0, "R10 stamp readback", r);
    idle(7);
    issue(3'd4, 4'd5, mk(5, 0, 0, 11, 0), 0, 0, "R10 stamp again", r);
    issue(3'd0, 4'd5, mk(0, 11, 0, 0, 0), 0, 0, "R10 second readback", r);

    // R11: refused operations change nothing
    issue(3'd4, 4'd4, mk(1, 0, 0, 9, 0), 0, 0, "R11 cp4 opcode1", r);
    idle(2);
    check(fiqN == 1'b1, "R11 fiq untouched", {31'd0, fiqN}, 32'd1);
    issue(3'd4, 4'd4, mk(5, 0, 0, 12, 0), 0, 0, "R11 cp4 stamp", r);
    issue(3'd0, 4'd4, mk(0, 12, 0, 0, 0), 0, 0, "R11 reg12 untouched", r);
    issue(3'd4, 4'd5, mk(6, 0, 0, 12, 0), 0, 0, "R11 cp5 opcode6", r);
    issue(3'd4, 4'd5, mk(15, 0, 0, 12, 0), 0, 0, "R11 cp5 opcode15", r);
    issue(3'd1, 4'd6, mk(0, 12, 0, 0, 0), 32'hFFFF, 0, "R11 other cp write", r);
    issue(3'd0, 4'd4, mk(0, 12, 0, 0, 0), 0, 0, "R11 reg12 still clear", r);
    issue(3'd5, 4'd4, mk(0, 12, 0, 0, 0), 0, 0, "R11 unknown kind", r);

    idle(3);
    summary();
    $finish;
  end
endmodule